// File: doc/BRIEF.md
# Single-Fault RAM Emulation Wrapper

This block sits between a memory test generator and a small synchronous RAM of one-bit words, and makes that RAM behave as if one cell were faulty. This lets a march or pattern test be scored on whether it finds the fault. The tester issues one request per cycle: a valid flag, a write enable, an address and a data bit. The wrapper forwards each request to the cell array it holds. A read returns its data one cycle after it is accepted.

A set of configuration inputs picks the fault model and its arguments. The models are transparent, stuck cell, blocked transition, idempotent coupling and inversion coupling. The arguments are the victim address, the aggressor address, the forced or blocked value (`cfg_val`) and the aggressor transition direction (`cfg_dir`). Single-cell faults are applied by rewriting the data of a write to the victim, and by overriding reads of a stuck victim. Coupling faults look at every write to the aggressor. A write that really changes the aggressor's stored bit in the selected direction sends the controller's state machine from `ST_PASS` to `ST_INJECT` for one cycle. In that cycle the wrapper writes the victim itself, with a forced value or an inverted value, while `req_ready` is low. The machine then returns unconditionally from `ST_INJECT` to `ST_PASS`. Every other cycle it stays in `ST_PASS`.

Configuration is expected to change only when the tester has no request in flight. The victim and the aggressor are expected to be different addresses.

Top module: `ramfault_wrap`

## Requirements
- R1: With `cfg_kind` = 0 (transparent; codes 5 to 7 behave the same), a read of any address returns the value last written there.
- R2: With `cfg_kind` = 1 (stuck), every read of the victim returns `cfg_val`, both before and after any write to it.
- R3: With `cfg_kind` = 2 and `cfg_val` = 0, a write of 1 to a victim that holds 0 leaves the victim at 0.
- R4: With `cfg_kind` = 2 and `cfg_val` = 1, a write of 0 to a victim that holds 1 leaves the victim at 1. A write of 1 to a victim that holds 0 takes effect.
- R5: With `cfg_kind` = 3 (idempotent coupling), an accepted write that changes the aggressor's bit to `cfg_dir` sets the victim to `cfg_val`. This holds whether `cfg_val` equals `cfg_dir` or not.
- R6: Under coupling, a write to the aggressor that keeps its stored value, or that moves it opposite to `cfg_dir`, leaves the victim unchanged and causes no stall.
- R7: With `cfg_kind` = 4 (inversion coupling), each triggering aggressor write inverts the victim.
- R8: After a triggering aggressor write, `req_ready` is low for exactly one cycle, and a request held during that cycle is accepted only after it.
- R9: A read accepted at a clock edge raises `rd_valid`, with its `rd_data`, after that edge and for that cycle only.
- R10: After reset, `req_ready` is high, `rd_valid` is low and every cell reads 0.
- R11: Addresses other than the victim are never altered by any fault model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the array |
| cfg_kind | input | 3 | Fault model: 0 none, 1 stuck, 2 transition, 3 idempotent coupling, 4 inversion coupling |
| cfg_vic | input | ADDR_W | Victim address |
| cfg_agg | input | ADDR_W | Aggressor address |
| cfg_val | input | 1 | Stuck value, blocked-transition start value, or forced victim value |
| cfg_dir | input | 1 | Aggressor transition direction that triggers coupling (1 rising, 0 falling) |
| req_valid | input | 1 | Tester request present |
| req_we | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 1 | Write data |
| req_ready | output | 1 | Request accepted this cycle when high |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 1 | Read data |

## Verification
The bench builds the wrapper with `ADDR_W` = 3, so it has eight cells. Address 2 is the victim and address 5 is the aggressor. This leaves both neighbours of the victim, and an address above the aggressor, to show that no other cell is disturbed. With an array this small, a reset between vector groups clears the whole array. Each group can therefore start from known contents. Every fault model can be swept under both polarities, and the stall can be probed with a request held high through the injection cycle.

// File: rtl/rfw_pkg.sv
package rfw_pkg;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_STUCK = 3'd1,
        K_TRANS = 3'd2,
        K_IDEM  = 3'd3,
        K_INV   = 3'd4
    } fault_kind_e;

    typedef enum logic {
        ST_PASS   = 1'b0,
        ST_INJECT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/rfw_ram.sv
module rfw_ram #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wdata,
    output logic              rdata,
    input  logic [ADDR_W-1:0] peek_a_addr,
    output logic              peek_a,
    input  logic [ADDR_W-1:0] peek_b_addr,
    output logic              peek_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] cells;
    logic             q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells <= '0;
            q     <= 1'b0;
        end else begin
            if (we) begin
                cells[addr] <= wdata;
            end
            if (re) begin
                q <= cells[addr];
            end
        end
    end

    assign rdata  = q;
    assign peek_a = cells[peek_a_addr];
    assign peek_b = cells[peek_b_addr];

    // R1: a write lands in the addressed cell
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> cells[$past(addr)] == $past(wdata));

endmodule

// File: rtl/rfw_ctrl.sv
module rfw_ctrl
    import rfw_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_kind,
    input  logic [ADDR_W-1:0] cfg_vic,
    input  logic [ADDR_W-1:0] cfg_agg,
    input  logic              cfg_val,
    input  logic              cfg_dir,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    output logic              req_ready,
    input  logic              vic_now,
    input  logic              agg_now,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wdata,
    output logic              rd_stuck
);
    ctl_state_e state, state_nx;

    logic is_stuck, is_trans, is_idem, is_inv, is_coupled;
    logic hit_vic, hit_agg, take_wr, take_rd, trigger;

    assign is_stuck   = (cfg_kind == K_STUCK);
    assign is_trans   = (cfg_kind == K_TRANS);
    assign is_idem    = (cfg_kind == K_IDEM);
    assign is_inv     = (cfg_kind == K_INV);
    assign is_coupled = is_idem | is_inv;

    assign hit_vic = (req_addr == cfg_vic);
    assign hit_agg = (req_addr == cfg_agg);
    assign take_wr = (state == ST_PASS) && req_valid && req_we;
    assign take_rd = (state == ST_PASS) && req_valid && !req_we;
    assign trigger = take_wr && hit_agg && is_coupled &&
                     (req_wdata != agg_now) && (req_wdata == cfg_dir);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PASS;
        end else begin
            state <= state_nx;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx  = state;
        req_ready = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = req_addr;
        mem_wdata = req_wdata;
        rd_stuck  = 1'b0;
        unique case (state)
            ST_PASS: begin
                req_ready = 1'b1;
                mem_we    = take_wr;
                mem_re    = take_rd;
                rd_stuck  = take_rd && is_stuck && hit_vic;
                if (hit_vic && is_stuck) begin
                    mem_wdata = cfg_val;
                end else if (hit_vic && is_trans && (vic_now == cfg_val)) begin
                    mem_wdata = cfg_val;
                end
                if (trigger) begin
                    state_nx = ST_INJECT;
                end
            end
            ST_INJECT: begin
                mem_we    = 1'b1;
                mem_addr  = cfg_vic;
                mem_wdata = is_idem ? cfg_val : ~vic_now;
                state_nx  = ST_PASS;
            end
        endcase
    end

    // R8: the injection cycle never repeats
    a_r8_one_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    // R8: configuration held while the injection is under way
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INJECT) |-> ($stable(cfg_kind) && $stable(cfg_vic) &&
                                  $stable(cfg_val)));

    // R5: idempotent injection leaves the victim at the forced value
    a_r5_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INJECT && is_idem) |=> vic_now == $past(cfg_val));

    // R7: inversion injection flips the victim
    a_r7_flipped: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INJECT && is_inv) |=> vic_now != $past(vic_now));

    // R2: a write to a stuck victim leaves it at the stuck value
    a_r2_stuck_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (take_wr && is_stuck && hit_vic) |=> vic_now == $past(cfg_val));

    // R6: an aggressor write that keeps its value does not stall
    a_r6_no_change_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (take_wr && hit_agg && req_wdata == agg_now) |=> req_ready);

endmodule

// File: rtl/ramfault_wrap.sv
module ramfault_wrap
    import rfw_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_kind,
    input  logic [ADDR_W-1:0] cfg_vic,
    input  logic [ADDR_W-1:0] cfg_agg,
    input  logic              cfg_val,
    input  logic              cfg_dir,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic              rd_data
);
    logic              vic_now, agg_now;
    logic              mem_we, mem_re, mem_wdata, mem_q;
    logic [ADDR_W-1:0] mem_addr;
    logic              rd_stuck;
    logic              rd_valid_q, force_q, force_val_q;

    rfw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_kind  (cfg_kind),
        .cfg_vic   (cfg_vic),
        .cfg_agg   (cfg_agg),
        .cfg_val   (cfg_val),
        .cfg_dir   (cfg_dir),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .vic_now   (vic_now),
        .agg_now   (agg_now),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rd_stuck  (rd_stuck)
    );

    rfw_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (mem_we),
        .re          (mem_re),
        .addr        (mem_addr),
        .wdata       (mem_wdata),
        .rdata       (mem_q),
        .peek_a_addr (cfg_vic),
        .peek_a      (vic_now),
        .peek_b_addr (cfg_agg),
        .peek_b      (agg_now)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_q  <= 1'b0;
            force_q     <= 1'b0;
            force_val_q <= 1'b0;
        end else begin
            rd_valid_q  <= mem_re;
            force_q     <= rd_stuck;
            force_val_q <= cfg_val;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = force_q ? force_val_q : mem_q;

    // R9: an accepted read yields valid data on the next cycle
    a_r9_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_we) |=> rd_valid);

    // R9: no read data without an accepted read
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready && !req_we) |=> !rd_valid);

endmodule

// File: tb/test_ramfault_wrap.sv
module test_ramfault_wrap;

    localparam int AW = 3;
    localparam logic [AW-1:0] VIC = 3'd2;
    localparam logic [AW-1:0] AGG = 3'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_kind = '0;
    logic [AW-1:0] cfg_vic = VIC;
    logic [AW-1:0] cfg_agg = AGG;
    logic          cfg_val = 1'b0;
    logic          cfg_dir = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_wdata = 1'b0;
    logic          req_ready, rd_valid, rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ramfault_wrap #(.ADDR_W(AW)) i_ramfault_wrap (
        .clk(clk), .rst_n(rst_n), .cfg_kind(cfg_kind), .cfg_vic(cfg_vic),
        .cfg_agg(cfg_agg), .cfg_val(cfg_val), .cfg_dir(cfg_dir),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    // rq: requirement number; rs: reset first; e: read value or stall flag
    typedef struct packed {
        logic [3:0]    rq;
        logic          rs;
        logic [2:0]    kind;
        logic          x;
        logic          y;
        logic          we;
        logic [AW-1:0] addr;
        logic          d;
        logic          e;
    } vec_t;

    localparam int NV = 54;
    localparam vec_t VEC [NV] = '{
        // transparent (R1, R11)
        '{4'd1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0},
        '{4'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1},
        '{4'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd5, 1'b1, 1'b0},
        '{4'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1},
        '{4'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0},
        '{4'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0},
        '{4'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd5, 1'b0, 1'b1},
        // stuck at 1 (R2)
        '{4'd2, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1},
        '{4'd2, 1'b0, 3'd1, 1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0},
        '{4'd2, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1},
        '{4'd11,1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0},
        '{4'd11,1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0},
        // stuck at 0 (R2)
        '{4'd2, 1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0},
        '{4'd2, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0},
        '{4'd11,1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 3'd3, 1'b1, 1'b0},
        '{4'd11,1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b1},
        // transition 0->1 blocked (R3)
        '{4'd3, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0},
        '{4'd3, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0},
        '{4'd3, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0},
        '{4'd3, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0},
        '{4'd11,1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 1'b0},
        '{4'd11,1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1},
        // transition 1->0 blocked (R4)
        '{4'd4, 1'b1, 3'd2, 1'b1, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0},
        '{4'd4, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1},
        '{4'd4, 1'b0, 3'd2, 1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0},
        '{4'd4, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1},
        // idempotent, rising aggressor forces 1 (R5, R6)
        '{4'd5, 1'b1, 3'd3, 1'b1, 1'b1, 1'b1, 3'd5, 1'b1, 1'b1},
        '{4'd5, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 1'b1},
        '{4'd5, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0, 3'd5, 1'b0, 1'b1},
        '{4'd6, 1'b0, 3'd3, 1'b1, 1'b1, 1'b1, 3'd2, 1'b0, 1'b0},
        '{4'd6, 1'b0, 3'd3, 1'b1, 1'b1, 1'b1, 3'd5, 1'b1, 1'b0},
        '{4'd6, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0},
        '{4'd6, 1'b0, 3'd3, 1'b1, 1'b1, 1'b1, 3'd5, 1'b0, 1'b0},
        '{4'd6, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0},
        '{4'd5, 1'b0, 3'd3, 1'b1, 1'b1, 1'b1, 3'd5, 1'b1, 1'b1},
        '{4'd5, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 1'b1},
        '{4'd11,1'b0, 3'd3, 1'b1, 1'b1, 1'b0, 3'd6, 1'b0, 1'b0},
        // idempotent, falling aggressor forces 0 (R5, R6)
        '{4'd5, 1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0},
        '{4'd6, 1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 3'd5, 1'b1, 1'b0},
        '{4'd6, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1},
        '{4'd5, 1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 3'd5, 1'b0, 1'b1},
        '{4'd5, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0},
        // idempotent, asymmetric: rising forces 0 (R5)
        '{4'd5, 1'b1, 3'd3, 1'b0, 1'b1, 1'b1, 3'd2, 1'b1, 1'b0},
        '{4'd5, 1'b0, 3'd3, 1'b0, 1'b1, 1'b1, 3'd5, 1'b1, 1'b1},
        '{4'd5, 1'b0, 3'd3, 1'b0, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0},
        // inversion, rising aggressor (R7, R6)
        '{4'd7, 1'b1, 3'd4, 1'b0, 1'b1, 1'b1, 3'd5, 1'b1, 1'b1},
        '{4'd7, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 3'd2, 1'b0, 1'b1},
        '{4'd6, 1'b0, 3'd4, 1'b0, 1'b1, 1'b1, 3'd5, 1'b0, 1'b0},
        '{4'd6, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 3'd2, 1'b0, 1'b1},
        '{4'd7, 1'b0, 3'd4, 1'b0, 1'b1, 1'b1, 3'd5, 1'b1, 1'b1},
        '{4'd7, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0},
        '{4'd11,1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0},
        // unused code behaves as transparent (R1)
        '{4'd1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 3'd5, 1'b1, 1'b0},
        '{4'd1, 1'b0, 3'd6, 1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0}
    };

    task automatic check(input string rq, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = 1'b0;
        rst_n     = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic op(input string rq, input logic we, input logic [AW-1:0] a,
                      input logic d, input logic e);
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (we) begin
            check({rq, " stall"}, !req_ready, e);
            check({rq, " no rd_valid after write (R9)"}, rd_valid, 1'b0);
        end else begin
            check({rq, " rd_valid"}, rd_valid, 1'b1);
            check({rq, " rd_data"}, rd_data, e);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R10: reset state
        check("R10 ready after reset", req_ready, 1'b1);
        check("R10 rd_valid after reset", rd_valid, 1'b0);
        op("R10 cleared cell", 1'b0, 3'd7, 1'b0, 1'b0);
        op("R10 cleared victim", 1'b0, VIC, 1'b0, 1'b0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].rs) do_reset();
            @(negedge clk);
            cfg_kind = VEC[k].kind;
            cfg_val  = VEC[k].x;
            cfg_dir  = VEC[k].y;
            op($sformatf("R%0d vec %0d", VEC[k].rq, k), VEC[k].we,
               VEC[k].addr, VEC[k].d, VEC[k].e);
        end

        // R8: a request held through the injection cycle
        do_reset();
        @(negedge clk);
        cfg_kind = 3'd4;
        cfg_val  = 1'b0;
        cfg_dir  = 1'b1;
        req_valid = 1'b1;
        req_we    = 1'b1;
        req_addr  = AGG;
        req_wdata = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8 ready low in injection cycle", req_ready, 1'b0);
        req_addr  = 3'd3;
        req_wdata = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8 ready back after one cycle", req_ready, 1'b1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 held write no second stall", req_ready, 1'b1);
        op("R8 held write landed", 1'b0, 3'd3, 1'b0, 1'b1);
        op("R7 victim inverted once", 1'b0, VIC, 1'b0, 1'b1);

        // R9: rd_valid lasts one cycle
        @(negedge clk);
        check("R9 rd_valid drops when idle", rd_valid, 1'b0);

        finish_run();
    end

endmodule